// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a processor tick timer with two registers on a small register bus. The count register is a free-running 32-bit counter. It advances by one on every cycle where the tick-enable input is high and the timer is running. The control register holds a 28-bit period value, an interrupt enable, a sticky interrupt pending flag and a two-bit mode selector. In normal use the tick-enable pulses come from a prescaler outside the block, nominally at 20 MHz (one tick per 50 ns).

A match occurs when a tick brings the low 28 bits of the count to the period value. The upper count bits play no part in the compare. When the period is at or below the current low field, the match therefore comes only after that field wraps through zero. On a match, the mode selects what the counter does next: keep counting, clear to zero and go on, or stop and hold. If interrupts are enabled, the match also sets the pending flag. The interrupt output is high while the flag and the enable are both set. Software can start and stop counting with two pulse inputs, and it can load the count at any time.

Top module: `tick_timer`

## Requirements
- R1: After reset the count reads 0, the control register reads 0, the timer is stopped and `irq` is low.
- R2: While running, the count rises by exactly one on each cycle with `tick_en` high (wrapping 0xFFFFFFFF to 0), and holds on cycles with `tick_en` low.
- R3: A `run_start` pulse makes the timer run from the next cycle on. A `run_stop` pulse halts it, and stop wins when both arrive together. While halted the count holds whatever `tick_en` does.
- R4: A bus write to address 0 loads the count on the next edge. It takes priority over a tick in the same cycle, and no match is evaluated in that cycle.
- R5: A match occurs on a tick whose incremented count has its bits 27:0 equal to control bits 27:0 (period). Count bits 31:28 are ignored.
- R6: When the period is at or below the current count bits 27:0, no match occurs until those bits wrap past 0x0FFFFFFF and climb to the period.
- R7: Mode 01 (restart, control bits 31:30): on a match the count becomes 0 and counting continues.
- R8: Mode 10 (one-shot): on a match the count takes the match value, the timer stops, and the count holds through later ticks.
- R9: Modes 00 (none) and 11 (continuous): a match leaves counting unaffected, and the count keeps incrementing.
- R10: A match with the enable (control bit 29) set sets the pending flag (control bit 28). A match with the enable clear leaves the flag unchanged.
- R11: The pending flag stays set until a control write puts 0 in bit 28. If a match with the enable set lands in the same cycle as a clearing write, the flag ends up set.
- R12: `irq` equals the pending flag ANDed with the enable, in both directions. A pending flag with the enable clear does not drive `irq`.
- R13: A bus write to address 1 stores all 32 control bits. Reading address 0 or 1 returns the count or the control register combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle tick pulse from the prescaler |
| run_start | input | 1 | Pulse: start counting |
| run_stop | input | 1 | Pulse: stop counting (wins over start) |
| bus_addr | input | 1 | Register select: 0 count, 1 control |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Timer interrupt request |

## Verification
The bench loads counts whose upper bits differ from the period. A design that compared the full word would then never match. It places a count just below the field maximum with a small period, so a design that skipped the wrap, or matched on a smaller-than comparison, would raise the flag too early. It makes a clearing write coincide with a match, where a design that let the write win would lose an interrupt. It also checks that a one-shot match holds the count at the match value rather than at the value after it, and that a count load in the same cycle as a tick suppresses the increment.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    MODE_NONE    = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_CONT    = 2'b11
  } tt_mode_e;

  localparam int unsigned CTRL_FLAG_BITS = 4;
endpackage

// File: rtl/tt_match.sv
module tt_match #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PER_W  = DATA_W - tt_pkg::CTRL_FLAG_BITS
) (
  input  logic              running,
  input  logic              tick_en,
  input  logic              cnt_load,
  input  logic [DATA_W-1:0] count,
  input  logic [PER_W-1:0]  period,
  output logic [DATA_W-1:0] count_inc,
  output logic              hit
);
  function automatic logic [DATA_W-1:0] step_count(input logic [DATA_W-1:0] c);
    return c + DATA_W'(1);
  endfunction

  function automatic logic field_eq(input logic [DATA_W-1:0] c, input logic [PER_W-1:0] p);
    return c[PER_W-1:0] == p;
  endfunction

  logic advancing;
  assign advancing = running & tick_en & ~cnt_load;
  assign count_inc = step_count(count);
  assign hit       = advancing & field_eq(count_inc, period);
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              run_start,
  input  logic              run_stop,
  input  logic              cnt_load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] count_inc,
  input  logic              hit,
  input  tt_mode_e          mode,
  output logic [DATA_W-1:0] count,
  output logic              running
);
  logic restart_hit;
  logic oneshot_hit;
  assign restart_hit = hit & (mode == MODE_RESTART);
  assign oneshot_hit = hit & (mode == MODE_ONESHOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (cnt_load) begin
      count <= load_val;
    end else if (running && tick_en) begin
      count <= restart_hit ? '0 : count_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            running <= 1'b0;
    else if (run_stop)     running <= 1'b0;
    else if (oneshot_hit)  running <= 1'b0;
    else if (run_start)    running <= 1'b1;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick_en && !cnt_load && !restart_hit) |=> count == $past(count) + DATA_W'(1)); // R2
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !cnt_load) |=> $stable(count)); // R3
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> count == $past(load_val)); // R4
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart_hit |=> count == '0); // R7
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot_hit && !run_start) |=> !running); // R8
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    run_stop |=> !running); // R3
endmodule

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
  import tt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PER_W  = DATA_W - CTRL_FLAG_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit,
  output tt_mode_e          mode,
  output logic              irq_en,
  output logic              pending,
  output logic [PER_W-1:0]  period,
  output logic [DATA_W-1:0] ctrl_word,
  output logic              irq
);
  localparam int unsigned MODE_LO = DATA_W - 2;
  localparam int unsigned IE_BIT  = DATA_W - 3;
  localparam int unsigned IP_BIT  = DATA_W - 4;

  logic set_pend;
  assign set_pend = hit & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= MODE_NONE;
      irq_en  <= 1'b0;
      pending <= 1'b0;
      period  <= '0;
    end else begin
      if (ctrl_wr) begin
        mode    <= tt_mode_e'(wdata[DATA_W-1:MODE_LO]);
        irq_en  <= wdata[IE_BIT];
        period  <= wdata[PER_W-1:0];
        pending <= wdata[IP_BIT] | set_pend;
      end else if (set_pend) begin
        pending <= 1'b1;
      end
    end
  end

  assign ctrl_word = {mode, irq_en, pending, period};
  assign irq       = pending & irq_en;

  AST_PEND_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    set_pend |=> pending); // R10
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ctrl_wr) |=> pending); // R11
  AST_NO_PEND_NO_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !ctrl_wr && !set_pend) |=> !pending); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R12
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              run_start,
  input  logic              run_stop,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int unsigned PER_W = DATA_W - CTRL_FLAG_BITS;

  logic              cnt_load;
  logic              ctrl_wr;
  logic              running;
  logic              hit;
  logic              irq_en;
  logic              pending;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] count_inc;
  logic [DATA_W-1:0] ctrl_word;
  logic [PER_W-1:0]  period;
  tt_mode_e          mode;

  assign cnt_load = bus_wr & ~bus_addr;
  assign ctrl_wr  = bus_wr & bus_addr;

  tt_match #(.DATA_W(DATA_W), .PER_W(PER_W)) u_match (
    .running(running), .tick_en(tick_en), .cnt_load(cnt_load),
    .count(count), .period(period), .count_inc(count_inc), .hit(hit)
  );

  tt_counter #(.DATA_W(DATA_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_start(run_start),
    .run_stop(run_stop), .cnt_load(cnt_load), .load_val(bus_wdata),
    .count_inc(count_inc), .hit(hit), .mode(mode),
    .count(count), .running(running)
  );

  tt_ctrl_reg #(.DATA_W(DATA_W), .PER_W(PER_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
    .hit(hit), .mode(mode), .irq_en(irq_en), .pending(pending),
    .period(period), .ctrl_word(ctrl_word), .irq(irq)
  );

  assign bus_rdata = bus_addr ? ctrl_word : count;

  AST_MATCH_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (mode != MODE_RESTART || $past(ctrl_wr) || count == '0)); // R5
  AST_HIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (tick_en && running && !cnt_load)); // R5
endmodule

// File: tb/sim_tick_timer.sv
`timescale 1ns/100ps
module sim_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, run_start = 1'b0, run_stop = 1'b0;
  logic        bus_addr = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_start(run_start),
    .run_stop(run_stop), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Behavioural reference
  longint unsigned m_cnt;
  int  m_mode, m_per;
  bit  m_ie, m_pend, m_run;

  always @(posedge clk) begin
    longint unsigned nxt;
    bit hitv;
    if (!rst_n) begin
      m_cnt <= 0; m_mode <= 0; m_per <= 0; m_ie <= 0; m_pend <= 0; m_run <= 0;
    end else begin
      hitv = 0;
      nxt  = (m_cnt + 1) % 64'h1_0000_0000;
      if (bus_wr && !bus_addr) m_cnt <= bus_wdata;
      else if (m_run && tick_en) begin
        hitv = ((nxt % 64'h1000_0000) == longint'(m_per));
        m_cnt <= (hitv && m_mode == 1) ? 0 : nxt;
      end
      if (bus_wr && bus_addr) begin
        m_mode <= bus_wdata[31:30]; m_ie <= bus_wdata[29]; m_per <= bus_wdata[27:0];
        m_pend <= bus_wdata[28] | (hitv & m_ie);
      end else if (hitv && m_ie) m_pend <= 1;
      if (run_stop) m_run <= 0;
      else if (hitv && m_mode == 2) m_run <= 0;
      else if (run_start) m_run <= 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (bus_addr) check("R13", bus_rdata, {m_mode[1:0], m_ie, m_pend, m_per[27:0]});
      else          check("R2", bus_rdata, m_cnt[31:0]);
      check("R12", {31'b0, irq}, {31'b0, m_pend & m_ie});
    end
  end

  function automatic logic [31:0] cw(int md, bit ie, bit ip, int per);
    return {md[1:0], ie, ip, per[27:0]};
  endfunction

  task automatic cyc(bit tk, bit st, bit sp, bit wr, bit ad, logic [31:0] wd);
    @(negedge clk);
    tick_en = tk; run_start = st; run_stop = sp; bus_wr = wr; bus_addr = ad; bus_wdata = wd;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(bit ad, output logic [31:0] v);
    cyc(0, 0, 0, 0, ad, 0);
    #0.5 v = bus_rdata;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rd(0, v); check("R1 count", v, 0);
    rd(1, v); check("R1 ctrl", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rst_n = 1'b1;
    ticks(3);
    rd(0, v); check("R3 stopped hold", v, 0);
    cyc(0, 1, 0, 0, 0, 0);
    ticks(5);
    cyc(0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0);
    ticks(2);
    rd(0, v); check("R2 increments", v, 7);
    cyc(0, 0, 0, 1, 0, 32'hFFFF_FFFE); ticks(2);
    rd(0, v); check("R2 wrap", v, 32'h0000_0000);
    cyc(1, 0, 0, 1, 0, 32'h1234_5678);
    rd(0, v); check("R4 load over tick", v, 32'h1234_5678);
    cyc(0, 1, 1, 0, 0, 0); ticks(3);
    rd(0, v); check("R3 stop wins", v, 32'h1234_5678);
    // none mode, upper bits differ from period
    cyc(0, 0, 0, 1, 1, cw(0, 1, 0, 10));
    cyc(0, 1, 0, 1, 0, 32'hF000_0005);
    ticks(4);
    rd(1, v); check("R5 no early match", {31'b0, v[28]}, 0);
    ticks(1);
    rd(1, v); check("R5 match ignores high bits", {31'b0, v[28]}, 1);
    check("R12 irq high", {31'b0, irq}, 1);
    ticks(3);
    rd(0, v); check("R9 none keeps counting", v, 32'hF000_000D);
    rd(1, v); check("R11 sticky", {31'b0, v[28]}, 1);
    cyc(0, 0, 0, 1, 1, cw(0, 1, 0, 10));
    rd(1, v); check("R11 sw clear", {31'b0, v[28]}, 0);
    // restart mode
    cyc(0, 0, 0, 1, 1, cw(1, 0, 0, 3));
    cyc(0, 0, 0, 1, 0, 0);
    ticks(3);
    rd(0, v); check("R7 restart zero", v, 0);
    ticks(2);
    rd(0, v); check("R7 continues", v, 2);
    rd(1, v); check("R10 no pend without ie", {31'b0, v[28]}, 0);
    // one-shot
    cyc(0, 0, 0, 1, 1, cw(2, 1, 0, 4));
    cyc(0, 0, 0, 1, 0, 0);
    ticks(4);
    rd(0, v); check("R8 oneshot value", v, 4);
    ticks(3);
    rd(0, v); check("R8 oneshot hold", v, 4);
    check("R10 pend set", {31'b0, irq}, 1);
    // continuous with wrap of field
    cyc(0, 0, 0, 1, 1, cw(3, 1, 0, 1));
    cyc(0, 1, 0, 1, 0, 32'h0FFF_FFFE);
    ticks(2);
    rd(1, v); check("R6 no match before wrap", {31'b0, v[28]}, 0);
    ticks(1);
    rd(1, v); check("R6 match after wrap", {31'b0, v[28]}, 1);
    ticks(1);
    rd(0, v); check("R9 continuous", v, 32'h1000_0002);
    // match coinciding with clear
    cyc(0, 0, 0, 1, 1, cw(0, 1, 1, 2));
    cyc(0, 0, 0, 1, 0, 0);
    ticks(1);
    cyc(1, 0, 0, 1, 1, cw(0, 1, 0, 2));
    rd(1, v); check("R11 match beats clear", {31'b0, v[28]}, 1);
    // pending without enable
    cyc(0, 0, 0, 1, 1, cw(0, 0, 1, 2));
    rd(1, v); check("R13 ctrl readback", v, cw(0, 0, 1, 2));
    check("R12 gated by ie", {31'b0, irq}, 0);
    cyc(0, 0, 0, 1, 1, cw(0, 1, 1, 2));
    rd(1, v); check("R12 ie enables irq", {31'b0, irq}, 1);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule